// File: doc/BRIEF.md
# Register-File ALU Shifter Datapath

This block is a 32-bit execution datapath with no sequencer of its own. Every control value arrives on a port and is acted on in the cycle it is presented. Two combinational read ports of a 32 x 32 register file feed an ALU. The ALU result passes through a logical barrel shifter.

The shifter result can be written back into the register file on the rising edge. A select input can instead pick an external load value, so the file can be filled from outside. Both read-port values and the shifter result are captured in rising-edge registers, and those three registers are the only outputs.

A driver, such as a testbench or a larger controller, steps the datapath one operation per clock. In each cycle it sets the read addresses, the ALU operation, the shift control and the write-back fields.

Top module: `rfalu_datapath`

## Requirements
- R1: While `rst_n` is low, all three output registers and every register-file entry are cleared to zero. After reset, every entry reads as zero.
- R2: One rising edge after `rd_addr_a` / `rd_addr_b` are presented, `port_a_q` / `port_b_q` hold the register-file contents at those addresses. The two ports are independent, and equal addresses give equal values.
- R3: Entry 0 always reads as zero, and a write to it has no effect.
- R4: An entry is written on the rising edge only when `wr_en` is 1. A read of the same entry in the same cycle returns the old value, and the new value is readable from the next cycle.
- R5: `wb_sel` = 1 writes `ext_data`. `wb_sel` = 0 writes the shifter result.
- R6: `alu_op` 0 gives A+B and 1 gives A-B. Both wrap modulo 2^32, so 500-1500 is stored as 32'hFFFFFC18.
- R7: `alu_op` 2 gives the bitwise AND of A and B, and `alu_op` 3 gives the bitwise OR.
- R8: `alu_op` 4 yields 1 when A < B as signed 32-bit numbers and 0 otherwise.
- R9: With `shift_en` = 1, `shift_dir` = 1 shifts the ALU result right logically by `shift_amt`, and `shift_dir` = 0 shifts it left. Vacated bits are zero.
- R10: With `shift_en` = 0, or with `shift_amt` = 0, the shifter passes the ALU result through unchanged.
- R11: Each rising edge captures the current shifter result into `shift_q`.
- R12: `alu_op` codes 5, 6 and 7 give an ALU result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register-file write enable |
| rd_addr_a | input | 5 | Read address, port A (ALU operand A) |
| rd_addr_b | input | 5 | Read address, port B (ALU operand B) |
| wr_addr | input | 5 | Write address |
| alu_op | input | 3 | ALU operation code |
| shift_en | input | 1 | Shifter enable |
| shift_dir | input | 1 | 1 = right logical, 0 = left logical |
| shift_amt | input | 5 | Shift distance |
| wb_sel | input | 1 | Write source: 1 = ext_data, 0 = shifter |
| ext_data | input | 32 | External load value |
| port_a_q | output | 32 | Registered read port A |
| port_b_q | output | 32 | Registered read port B |
| shift_q | output | 32 | Registered shifter result |

## Verification
All three outputs are due exactly one rising edge after the controls that produce them. A value written in cycle t becomes visible through a read port in cycle t+2. The bench drives its inputs two time units after a rising edge and samples the outputs two time units after the next one, so each check sees only the edge it targets. A bench-side register model is updated after the compare, which captures the rule that a same-cycle read returns the old value. Seeded random operations are mixed with directed cases for signed compare, wrap-around, logical right shift of negative values, entry 0, gated writes and undefined opcodes.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned REG_N  = 32;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_SLT = 3'd4
  } alu_op_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] entry [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign entry[i] = '0;
    end else begin : g_reg
      logic hit;
      assign hit = we && (waddr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   entry[i] <= '0;
        else if (hit) entry[i] <= wdata;
      end
    end
  end

  assign rdata_a = entry[raddr_a];
  assign rdata_b = entry[raddr_b];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  alu_op_e opc;
  assign opc = alu_op_e'(op);

  always_comb begin
    unique case (opc)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_SLT:  y = ($signed(a) < $signed(b)) ? WIDTH'(1) : '0;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dp_shifter.sv
module dp_shifter #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic             en,
  input  logic             right,
  input  logic [SW-1:0]    amt,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [SW+1];

  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned DIST = 1 << k;
    always_comb begin
      if (en && amt[k]) begin
        stage[k+1] = right ? (stage[k] >> DIST) : (stage[k] << DIST);
      end else begin
        stage[k+1] = stage[k];
      end
    end
  end

  assign dout = stage[SW];
endmodule

// File: rtl/rfalu_datapath.sv
module rfalu_datapath
  import dp_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  parameter int unsigned DEPTH = REG_N,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned SW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  input  logic [AW-1:0]    wr_addr,
  input  logic [OP_W-1:0]  alu_op,
  input  logic             shift_en,
  input  logic             shift_dir,
  input  logic [SW-1:0]    shift_amt,
  input  logic             wb_sel,
  input  logic [WIDTH-1:0] ext_data,
  output logic [WIDTH-1:0] port_a_q,
  output logic [WIDTH-1:0] port_b_q,
  output logic [WIDTH-1:0] shift_q
);
  logic [WIDTH-1:0] rd_a, rd_b, alu_y, sh_y, wb_data;

  dp_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wb_data),
    .raddr_a (rd_addr_a),
    .raddr_b (rd_addr_b),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  dp_alu #(.WIDTH(WIDTH)) u_alu (
    .op (alu_op),
    .a  (rd_a),
    .b  (rd_b),
    .y  (alu_y)
  );

  dp_shifter #(.WIDTH(WIDTH)) u_sh (
    .din   (alu_y),
    .en    (shift_en),
    .right (shift_dir),
    .amt   (shift_amt),
    .dout  (sh_y)
  );

  assign wb_data = wb_sel ? ext_data : sh_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_a_q <= '0;
      port_b_q <= '0;
      shift_q  <= '0;
    end else begin
      port_a_q <= rd_a;
      port_b_q <= rd_b;
      shift_q  <= sh_y;
    end
  end
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW = 5,
  parameter int unsigned SW = 5,
  parameter int unsigned OPW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    rd_addr_a,
  input logic [AW-1:0]    rd_addr_b,
  input logic [AW-1:0]    wr_addr,
  input logic [OPW-1:0]   alu_op,
  input logic             shift_en,
  input logic             shift_dir,
  input logic [SW-1:0]    shift_amt,
  input logic             wb_sel,
  input logic [WIDTH-1:0] ext_data,
  input logic [WIDTH-1:0] port_a_q,
  input logic [WIDTH-1:0] port_b_q,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] alu_y
);
  AST_SAME_ADDR_SAME_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == rd_addr_b) |=> (port_a_q == port_b_q)); // R2

  AST_ZERO_ENTRY_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |=> (port_a_q == '0)); // R3

  AST_ZERO_ENTRY_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |=> (port_b_q == '0)); // R3

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) ##1 $stable(rd_addr_a) |=> $stable(port_a_q)); // R4

  AST_EXT_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wb_sel && wr_addr != '0) ##1 (rd_addr_a == $past(wr_addr))
      |=> (port_a_q == $past(ext_data, 2))); // R5

  AST_SLT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == OPW'(4) && !shift_en) |=> (shift_q[WIDTH-1:1] == '0)); // R8

  AST_LEFT_FILLS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !shift_dir && shift_amt != '0) |=> (shift_q[0] == 1'b0)); // R9

  AST_RIGHT_FILLS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && shift_dir && shift_amt != '0) |=> (shift_q[WIDTH-1] == 1'b0)); // R9

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en || shift_amt == '0) |=> (shift_q == $past(alu_y))); // R10

  AST_UNDEF_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op > OPW'(4)) |=> (shift_q == '0)); // R12
endmodule

bind rfalu_datapath dp_checker #(
  .WIDTH (WIDTH),
  .AW    (AW),
  .SW    (SW),
  .OPW   (dp_pkg::OP_W)
) u_dp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_addr_a (rd_addr_a),
  .rd_addr_b (rd_addr_b),
  .wr_addr   (wr_addr),
  .alu_op    (alu_op),
  .shift_en  (shift_en),
  .shift_dir (shift_dir),
  .shift_amt (shift_amt),
  .wb_sel    (wb_sel),
  .ext_data  (ext_data),
  .port_a_q  (port_a_q),
  .port_b_q  (port_b_q),
  .shift_q   (shift_q),
  .alu_y     (alu_y)
);

// File: tb/test_rfalu_datapath.sv
module test_rfalu_datapath;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [2:0]  alu_op = '0;
  logic        shift_en = 1'b0, shift_dir = 1'b0, wb_sel = 1'b0;
  logic [4:0]  shift_amt = '0;
  logic [31:0] ext_data = '0;
  logic [31:0] port_a_q, port_b_q, shift_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] mdl [32];

  rfalu_datapath i_rfalu_datapath (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_addr_a(rd_addr_a),
    .rd_addr_b(rd_addr_b), .wr_addr(wr_addr), .alu_op(alu_op),
    .shift_en(shift_en), .shift_dir(shift_dir), .shift_amt(shift_amt),
    .wb_sel(wb_sel), .ext_data(ext_data), .port_a_q(port_a_q),
    .port_b_q(port_b_q), .shift_q(shift_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] alu_m(logic [31:0] a, logic [31:0] b, int op);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] sh_m(logic [31:0] v, bit en, bit right, int amt);
    if (!en) return v;
    return right ? (v >> amt) : (v << amt);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit we, int aa, int ab, int wa, int op, bit sen, bit sdir,
                     int samt, bit sel, logic [31:0] ext);
    logic [31:0] ea, eb, es;
    ea = mdl[aa];
    eb = mdl[ab];
    es = sh_m(alu_m(ea, eb, op), sen, sdir, samt);
    wr_en = we; rd_addr_a = 5'(aa); rd_addr_b = 5'(ab); wr_addr = 5'(wa);
    alu_op = 3'(op); shift_en = sen; shift_dir = sdir; shift_amt = 5'(samt);
    wb_sel = sel; ext_data = ext;
    @(posedge clk); #2;
    chk("R2 port A", port_a_q, ea);
    chk("R2 port B", port_b_q, eb);
    chk("R11 shift_q", shift_q, es);
    if (we && wa != 0) mdl[wa] = sel ? ext : es;
  endtask

  task automatic rdchk(string req, int a, logic [31:0] exp);
    cyc(0, a, 0, 0, 0, 0, 0, 0, 0, 32'd0);
    chk(req, port_a_q, exp);
  endtask

  task automatic load(int r, logic [31:0] v);
    cyc(1, 0, 0, r, 0, 0, 0, 0, 1, v);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset port_a_q", port_a_q, '0);
    chk("R1 reset port_b_q", port_b_q, '0);
    chk("R1 reset shift_q", shift_q, '0);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) rdchk("R1 entry cleared", i, 32'd0);

    load(1, 10); load(2, 15); load(3, 20); load(4, 25); load(5, 30);
    load(20, 500); load(21, 1500); load(22, 2500);
    rdchk("R5 ext load", 22, 32'd2500);

    cyc(1, 3, 5, 6, 0, 0, 0, 0, 0, 32'd0);      rdchk("R6 add", 6, 32'd50);
    cyc(1, 20, 21, 25, 1, 0, 0, 0, 0, 32'd0);   rdchk("R6 sub wrap", 25, 32'hFFFFFC18);
    cyc(1, 6, 0, 7, 0, 1, 1, 1, 0, 32'd0);      rdchk("R9 right 1", 7, 32'd25);
    cyc(1, 20, 0, 30, 0, 1, 0, 1, 0, 32'd0);    rdchk("R9 left 1", 30, 32'd1000);
    cyc(1, 1, 2, 8, 2, 0, 0, 0, 0, 32'd0);      rdchk("R7 and", 8, 32'd10);
    cyc(1, 21, 22, 9, 3, 0, 0, 0, 0, 32'd0);    rdchk("R7 or", 9, 32'd3548);
    cyc(1, 7, 5, 10, 4, 0, 0, 0, 0, 32'd0);     rdchk("R8 slt true", 10, 32'd1);
    cyc(1, 25, 1, 11, 4, 0, 0, 0, 0, 32'd0);    rdchk("R8 slt signed neg", 11, 32'd1);
    cyc(1, 1, 25, 12, 4, 0, 0, 0, 0, 32'd0);    rdchk("R8 slt false", 12, 32'd0);
    cyc(1, 30, 10, 31, 0, 0, 0, 0, 0, 32'd0);   rdchk("R6 add chain", 31, 32'd1001);
    cyc(1, 25, 0, 18, 0, 1, 1, 4, 0, 32'd0);    rdchk("R9 logical right", 18, 32'h0FFFFFC1);
    cyc(1, 21, 0, 13, 0, 1, 0, 0, 0, 32'd0);    rdchk("R10 amt zero", 13, 32'd1500);
    cyc(1, 21, 0, 14, 0, 0, 1, 7, 0, 32'd0);    rdchk("R10 disabled", 14, 32'd1500);
    load(0, 99);                                rdchk("R3 entry 0", 0, 32'd0);
    cyc(0, 0, 0, 15, 0, 0, 0, 0, 1, 32'd77);    rdchk("R4 gated", 15, 32'd0);
    cyc(1, 16, 0, 16, 0, 0, 0, 0, 1, 32'd123);
    chk("R4 same-cycle old", port_a_q, 32'd0);
    rdchk("R4 new next", 16, 32'd123);
    cyc(1, 1, 2, 17, 0, 0, 0, 0, 0, 32'd555);   rdchk("R5 shifter source", 17, 32'd25);
    cyc(1, 21, 22, 19, 5, 0, 0, 0, 0, 32'd0);
    chk("R12 op 5", shift_q, 32'd0);
    cyc(0, 21, 22, 0, 7, 0, 0, 0, 0, 32'd0);
    chk("R12 op 7", shift_q, 32'd0);
    rdchk("R12 written zero", 19, 32'd0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] ev;
      ev = ($urandom % 4 == 0) ? {1'b1, 31'($urandom)} : $urandom;
      cyc(bit'($urandom % 2), int'($urandom % 32), int'($urandom % 32),
          int'($urandom % 32), int'($urandom % 8), bit'($urandom % 2),
          bit'($urandom % 2), int'($urandom % 32), bit'($urandom % 2), ev);
    end
    for (int i = 0; i < 32; i++) rdchk("R2 final sweep", i, mdl[i]);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule